// File: doc/BRIEF.md
# USB Transmit Framer

This block is the transmit control path of a UTMI-style USB transceiver. A link controller hands it parallel bytes through a valid/ready handshake. Each byte goes into a single holding register and then into a shift register. From there the block serializes it onto a line-drive pair plus an output enable. Serialization advances one symbol per pulse of a bit-time strobe, so one parallel clock can serve different bit rates.

A rising `tx_valid` opens a packet. The block drives the SYNC pattern, then the data bits LSB first, with bit stuffing and NRZI in the normal mode. When `tx_valid` has gone low and every accepted bit has been sent, it closes the packet with an end-of-packet sequence and releases the output enable.

A 2-bit `op_mode` input selects the mode:
- 0: normal encoding.
- 1: non-driving.
- 2: raw mode, with stuffing and NRZI bypassed.
- 3: reserved, handled the same as non-driving.

Line symbols on (`line_dp`, `line_dm`) are encoded as J = (1,0), K = (0,1) and SE0 = (0,0).

Top module: `usb_tx_framer`

## Requirements
- R1: After reset, `line_oe` and `tx_ready` are low and the line shows J.
- R2: In a driving mode (0 or 2), a rising `tx_valid` sampled at a clock edge while idle makes `line_oe` high on the next clock cycle, with the line showing K. This holds without waiting for a strobe.
- R3: SYNC appears on the line as K J K J K J K K. While `line_oe` is high, the line changes only on a clock edge at which `bit_stb` is high, by one symbol per strobe.
- R4: `tx_ready` is high only while a packet is in progress in a driving mode and the holding register is empty. When `tx_valid` and `tx_ready` are both high at an edge, `tx_data` is captured, and `tx_ready` is low in the following cycle.
- R5: In mode 0, data bytes are sent LSB first with NRZI: a 0 bit toggles the line level and a 1 bit holds it.
- R6: In mode 0, after six consecutive 1 bits a 0 bit is inserted. The trailing 1 of SYNC counts toward the run, and a stuffed bit is still inserted after the last data bit of the packet.
- R7: After `tx_valid` is low and all accepted bits are sent, the line shows SE0 for two strobes and then J for one strobe. `line_oe` falls at the next strobe, and the line stays J.
- R8: In mode 2, data bits map directly to the line (1 = J, 0 = K) with no stuffing. SYNC and end-of-packet are unchanged.
- R9: In mode 1 or 3, `line_oe` and `tx_ready` stay low and a rising `tx_valid` starts nothing.
- R10: The line never shows SE1 (both `line_dp` and `line_dm` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Asynchronous active-high reset |
| bit_stb | input | 1 | Bit-time strobe, one pulse per line symbol |
| tx_valid | input | 1 | Controller has a byte; rise opens, fall closes a packet |
| tx_data | input | DATA_W | Byte offered by the controller |
| op_mode | input | 2 | 0 normal, 1 non-driving, 2 raw, 3 as non-driving |
| tx_ready | output | 1 | Holding register can take `tx_data` this cycle |
| line_dp | output | 1 | Positive line drive level |
| line_dm | output | 1 | Negative line drive level |
| line_oe | output | 1 | Line driver enable |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, an 8-symbol SYNC, a stuffing run of six and two SE0 symbols. With these values, a single all-ones byte after SYNC already reaches a stuffed bit. A byte ending in six ones reaches the stuffed bit that falls just before end-of-packet.

The bench drives the strobe every fourth clock for most packets and on every clock for one packet. The every-clock case brings the holding register refill race and the SYNC start that does not wait for a strobe within reach.

// File: rtl/usb_tx_framer.sv
module usb_tx_framer #(
  parameter int DATA_W    = 8,
  parameter int SYNC_BITS = 8,
  parameter int STUFF_RUN = 6,
  parameter int EOP_SE0   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [1:0]        op_mode,
  output logic              tx_ready,
  output logic              line_dp,
  output logic              line_dm,
  output logic              line_oe
);

  localparam int CW = $clog2(DATA_W + 1);
  localparam int SW = $clog2(SYNC_BITS);
  localparam int OW = $clog2(STUFF_RUN + 2);
  localparam int EW = $clog2(EOP_SE0 + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_DATA, ST_EOP} state_t;

  state_t            st_q;
  logic              valid_q, raw_q, hold_full, lvl_q, se0_q, oe_q;
  logic [DATA_W-1:0] hold_q, sh_q;
  logic [CW-1:0]     cnt_q;
  logic [OW-1:0]     ones_q;
  logic [SW-1:0]     sidx_q;
  logic [EW-1:0]     ecnt_q;

  logic drive_ok, start, take, stuff_now, have_bit, nb, enc, sync_last;

  assign drive_ok  = !op_mode[0];
  assign start     = (st_q == ST_IDLE) && tx_valid && !valid_q && drive_ok;
  assign tx_ready  = ((st_q == ST_SYNC) || (st_q == ST_DATA)) && !hold_full && drive_ok;
  assign take      = tx_valid && tx_ready;
  assign stuff_now = !raw_q && (ones_q == OW'(STUFF_RUN));
  assign have_bit  = (cnt_q != '0) || hold_full;
  assign nb        = (cnt_q != '0) ? sh_q[0] : hold_q[0];
  assign enc       = raw_q ? nb : (nb ? lvl_q : !lvl_q);
  assign sync_last = (sidx_q == SW'(SYNC_BITS - 2));

  assign line_dp = !se0_q && lvl_q;
  assign line_dm = !se0_q && !lvl_q;
  assign line_oe = oe_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      valid_q   <= 1'b0;
      raw_q     <= 1'b0;
      hold_full <= 1'b0;
      hold_q    <= '0;
      sh_q      <= '0;
      cnt_q     <= '0;
      ones_q    <= '0;
      sidx_q    <= '0;
      ecnt_q    <= '0;
      lvl_q     <= 1'b1;
      se0_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      valid_q <= tx_valid;
      if (take) begin
        hold_q    <= tx_data;
        hold_full <= 1'b1;
      end
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_SYNC;
          raw_q  <= op_mode[1];
          oe_q   <= 1'b1;
          lvl_q  <= 1'b0;
          se0_q  <= 1'b0;
          sidx_q <= '0;
          cnt_q  <= '0;
        end
        ST_SYNC: if (bit_stb) begin
          sidx_q <= sidx_q + 1'b1;
          if (!sync_last) lvl_q <= !lvl_q;
          if (sync_last) begin
            st_q   <= ST_DATA;
            ones_q <= OW'(1);
          end
        end
        ST_DATA: if (bit_stb) begin
          if (stuff_now) begin
            lvl_q  <= !lvl_q;
            ones_q <= '0;
          end else if (have_bit) begin
            lvl_q  <= enc;
            ones_q <= nb ? ones_q + 1'b1 : '0;
            if (cnt_q != '0) begin
              sh_q  <= sh_q >> 1;
              cnt_q <= cnt_q - 1'b1;
            end else begin
              sh_q      <= hold_q >> 1;
              cnt_q     <= CW'(DATA_W - 1);
              hold_full <= 1'b0;
            end
          end else begin
            st_q   <= ST_EOP;
            se0_q  <= 1'b1;
            ecnt_q <= EW'(1);
          end
        end
        ST_EOP: if (bit_stb) begin
          if (ecnt_q < EW'(EOP_SE0)) begin
            ecnt_q <= ecnt_q + 1'b1;
          end else if (ecnt_q == EW'(EOP_SE0)) begin
            se0_q  <= 1'b0;
            lvl_q  <= 1'b1;
            ecnt_q <= ecnt_q + 1'b1;
          end else begin
            oe_q <= 1'b0;
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/usb_tx_framer_chk.sv
module usb_tx_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_stb,
  input logic       tx_valid,
  input logic [1:0] op_mode,
  input logic       tx_ready,
  input logic       line_dp,
  input logic       line_dm,
  input logic       line_oe
);

  assert_sync_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!line_oe && tx_valid && !$past(tx_valid) && !op_mode[0]) |=> (line_oe && line_dm && !line_dp));

  assert_strobe_paced_R3: assert property (@(posedge clk) disable iff (rst)
    (line_oe && !bit_stb) |=> $stable({line_dp, line_dm, line_oe}));

  assert_ready_in_packet_R4: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> line_oe);

  assert_release_after_j_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(line_oe) |-> $past(line_dp && !line_dm && bit_stb));

  assert_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
    (!line_oe && op_mode[0]) |=> !line_oe);

  assert_no_se1_R10: assert property (@(posedge clk) disable iff (rst)
    !(line_dp && line_dm));

endmodule

bind usb_tx_framer usb_tx_framer_chk i_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .tx_valid(tx_valid), .op_mode(op_mode),
  .tx_ready(tx_ready), .line_dp(line_dp), .line_dm(line_dm), .line_oe(line_oe)
);

// File: tb/test_usb_tx_framer.sv
module test_usb_tx_framer;
  logic       clk = 1'b0, rst = 1'b1, bit_stb = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic [1:0] op_mode = 2'd0;
  logic       tx_ready, line_dp, line_dm, line_oe;

  usb_tx_framer i_usb_tx_framer (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .tx_valid(tx_valid), .tx_data(tx_data),
    .op_mode(op_mode), .tx_ready(tx_ready), .line_dp(line_dp), .line_dm(line_dm), .line_oe(line_oe)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int div = 4, dcnt = 0;
  logic stb_seen = 1'b0;
  int syms[512];
  int nsym = 0, stab_err = 0;
  int exp_s[512];
  int nexp = 0;
  logic [7:0] pkt[16];
  int pkt_n = 0;
  logic oe_prev = 1'b0;
  logic [1:0] prev_ln = 2'b10;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int cur_sym();
    if (line_dp && !line_dm) return 1;
    if (!line_dp && line_dm) return 2;
    if (!line_dp && !line_dm) return 0;
    return 3;
  endfunction

  always @(negedge clk) begin
    bit_stb = (dcnt == 0);
    dcnt = (dcnt + 1 >= div) ? 0 : dcnt + 1;
  end

  always @(posedge clk) stb_seen <= bit_stb;

  always @(negedge clk) begin
    if (line_oe && (stb_seen || !oe_prev)) begin
      if (nsym < 512) syms[nsym] = cur_sym();
      nsym++;
    end else if (line_oe && oe_prev && ({line_dp, line_dm} != prev_ln)) begin
      stab_err++;
    end
    prev_ln = {line_dp, line_dm};
    oe_prev = line_oe;
  end

  initial begin
    #1_500_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic build_exp(input bit raw);
    int lv, ones;
    nexp = 0;
    for (int i = 0; i < 7; i++) begin
      exp_s[nexp] = (i % 2 == 0) ? 2 : 1;
      nexp++;
    end
    exp_s[nexp] = 2; nexp++;
    lv = 2; ones = 1;
    for (int k = 0; k < pkt_n; k++) begin
      for (int b = 0; b < 8; b++) begin
        if (raw) begin
          exp_s[nexp] = pkt[k][b] ? 1 : 2; nexp++;
        end else begin
          if (pkt[k][b]) ones++;
          else begin ones = 0; lv = 3 - lv; end
          exp_s[nexp] = lv; nexp++;
          if (ones == 6) begin
            lv = 3 - lv; exp_s[nexp] = lv; nexp++; ones = 0;
          end
        end
      end
    end
    exp_s[nexp] = 0; nexp++;
    exp_s[nexp] = 0; nexp++;
    exp_s[nexp] = 1; nexp++;
  endtask

  task automatic run_packet(input string dreq, input logic [1:0] mode, input int dv);
    int idx, guard, bad_sync, bad_data, bad_eop, se1;
    bit took, first, rdy_checked;
    div = dv;
    op_mode = mode;
    build_exp(mode[1]);
    @(negedge clk);
    nsym = 0; stab_err = 0;
    chk(!tx_ready, "R4 ready low while idle", tx_ready, 0);
    tx_valid = 1'b1; tx_data = pkt[0];
    idx = 0; took = 1'b0; first = 1'b1; rdy_checked = 1'b0; guard = 0;
    while (idx < pkt_n && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (first) begin
        chk(line_oe && cur_sym() == 2, "R2 SYNC start one clock after rise", cur_sym(), 2);
        first = 1'b0;
      end
      if (took) begin
        if (!rdy_checked) begin
          chk(!tx_ready, "R4 ready low after capture", tx_ready, 0);
          rdy_checked = 1'b1;
        end
        idx++;
        if (idx < pkt_n) tx_data = pkt[idx];
        else tx_valid = 1'b0;
      end
      took = tx_valid && tx_ready;
    end
    guard = 0;
    while (line_oe && guard < 10000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    chk(!line_oe && cur_sym() == 1, "R7 released to idle J", cur_sym(), 1);
    chk(nsym == nexp, "R7 symbol count", nsym, nexp);
    bad_sync = 0; bad_data = 0; bad_eop = 0; se1 = 0;
    for (int i = 0; i < nexp && i < nsym; i++) begin
      if (syms[i] == 3) se1++;
      if (syms[i] != exp_s[i]) begin
        if (i < 8) bad_sync++;
        else if (i >= nexp - 3) bad_eop++;
        else bad_data++;
      end
    end
    chk(bad_sync == 0, "R3 SYNC pattern mismatches", bad_sync, 0);
    chk(bad_data == 0, dreq, bad_data, 0);
    chk(bad_eop == 0, "R7 end-of-packet mismatches", bad_eop, 0);
    chk(stab_err == 0, "R3 line change without strobe", stab_err, 0);
    chk(se1 == 0, "R10 SE1 symbols", se1, 0);
  endtask

  task automatic run_nodrive(input logic [1:0] mode);
    int seen_oe, seen_rdy;
    op_mode = mode;
    seen_oe = 0; seen_rdy = 0;
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 8'h5A;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (line_oe) seen_oe++;
      if (tx_ready) seen_rdy++;
    end
    tx_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(seen_oe == 0, "R9 output enable in non-driving mode", seen_oe, 0);
    chk(seen_rdy == 0, "R9 ready in non-driving mode", seen_rdy, 0);
    chk(cur_sym() == 1 && !line_oe, "R9 line idle after ignored rise", cur_sym(), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!line_oe, "R1 oe low after reset", line_oe, 0);
    chk(!tx_ready, "R1 ready low after reset", tx_ready, 0);
    chk(cur_sym() == 1, "R1 line J after reset", cur_sym(), 1);

    pkt[0] = 8'h00; pkt_n = 1;
    run_packet("R5 NRZI zeros mismatches", 2'd0, 4);

    pkt[0] = 8'hA5; pkt[1] = 8'h3C; pkt[2] = 8'h81; pkt_n = 3;
    run_packet("R5 NRZI mixed bytes mismatches", 2'd0, 4);

    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt_n = 2;
    run_packet("R6 stuffing in ones run mismatches", 2'd0, 4);

    pkt[0] = 8'h00; pkt[1] = 8'hFC; pkt_n = 2;
    run_packet("R6 stuffing before end-of-packet mismatches", 2'd0, 4);

    pkt[0] = 8'hFF; pkt[1] = 8'h0F; pkt[2] = 8'h3E; pkt_n = 3;
    run_packet("R8 raw mode mismatches", 2'd2, 4);

    pkt[0] = 8'h7E; pkt[1] = 8'hFF; pkt[2] = 8'h12; pkt[3] = 8'hC3; pkt_n = 4;
    run_packet("R4 R6 strobe every clock mismatches", 2'd0, 1);

    run_nodrive(2'd1);
    run_nodrive(2'd3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule